// File: doc/BRIEF.md
# Serial Receive Buffer with Character Timeout

This block is the receive side storage of a 16550-style serial port. A deserializer hands it one received byte, or a line-break event, per strobe. In buffered mode the bytes go into a 16-entry first-in first-out queue. In single-byte mode they go into one holding register. The block keeps the receive status flags: data available, overrun and break seen. It compares the queue fill against a programmable trigger level and exposes the result to the interrupt logic.

The block also runs a character timeout. The timer counts baud-rate tick pulses. It expires after four frame times, where the frame length comes from the word-length, parity and stop-bit fields of the line format. When it expires with data still queued, it raises a timeout-pending flag.

The host side has four controls. It reads received data through a read strobe, with the byte to be returned visible on `rd_data` in the same cycle. A status-read strobe clears the sticky error flags. A write to the FIFO control value selects the mode and the trigger level, and can flush the receive path.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the control value is 0x00 (single-byte mode), `fifo_count` is 0, and data-ready, overrun, break and timeout-pending are all 0.
- R2: In single-byte mode, each received byte replaces the holding register and sets data-ready. Overrun is set if data-ready was already 1 and no read occurs in the same cycle. A read returns the holding register and clears data-ready and break. In this mode `trig_hit` equals data-ready.
- R3: In buffered mode, bytes are read back in arrival order. A byte arriving with 16 entries stored and no read in the same cycle is dropped and sets overrun, and the stored entries are kept unchanged.
- R4: In buffered mode, a read of an empty queue returns 0x00. Data-ready and break clear in the cycle the queue becomes empty, and data-ready is 1 whenever the queue holds data.
- R5: A break event stores a 0x00 byte and sets both break and data-ready.
- R6: A status-read strobe clears overrun and break. Overrun otherwise stays set.
- R7: A control write keeps only bits 7, 6, 3 and 0 of the written value (mask 0xC9). Bit 0 selects buffered mode, and bits 7:6 select the trigger level.
- R8: Any control write that sets bit 1, or that changes bit 0, empties the queue and clears data-ready, break and timeout-pending. A write that does neither leaves the queue contents untouched.
- R9: `trig_hit` is 1 in buffered mode when `fifo_count` is at least 1, 4, 8 or 14, for level-select values 0, 1, 2 and 3.
- R10: The timeout is 4 × F baud ticks. F = 1 + (5 + fmt[1:0]) + fmt[3] + (fmt[2] ? 2 : 1), where fmt[1:0] is the word length, fmt[2] selects two stop bits and fmt[3] enables parity. Timeout-pending rises on the edge of the last tick.
- R11: Every received byte or break in buffered mode restarts the timer, and so does every read that leaves data in the queue. Any read in buffered mode clears timeout-pending, and an expiry with the queue empty leaves it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: `rx_data` holds a received byte |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | One-cycle strobe: a line break was received |
| rd_req | input | 1 | Data read strobe; pops one byte |
| stat_rd | input | 1 | Status read strobe; clears overrun and break |
| fcr_wr | input | 1 | Control write strobe |
| fcr_wdata | input | 8 | Control write value |
| lcr_fmt | input | 4 | Frame format: [1:0] word length − 5, [2] two stop bits, [3] parity on |
| baud_tick | input | 1 | One pulse per serial bit period |
| rd_data | output | 8 | Byte a read in this cycle returns |
| data_ready | output | 1 | Received data available |
| overrun | output | 1 | A byte was lost |
| break_seen | output | 1 | A break was received |
| timeout_pend | output | 1 | Character timeout pending |
| fifo_count | output | 5 | Bytes stored in the queue |
| trig_hit | output | 1 | Fill reached the trigger level |
| fcr_state | output | 8 | Retained control value |

## Verification
Every strobe takes effect on the clock edge that samples it. Flags, `fifo_count` and `trig_hit` are therefore due one edge after the strobe. `rd_data` is combinational and is due in the same cycle, before the pop. The bench drives strobes on the falling edge, removes them on the next falling edge, and samples there. At that point exactly one rising edge has passed. `rd_data` is sampled a moment after the read strobe is driven. For timeouts, the bench gives each tick its own cycle and counts ticks from the restart edge. It checks that the flag is still low after 4×F−1 ticks and high after the 4×F-th.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;

    localparam int         BYTE_W     = 8;
    localparam logic [7:0] FCR_KEEP   = 8'hC9;
    localparam int         FCR_EN     = 0;
    localparam int         FCR_RXRST  = 1;
    localparam int         FCR_TXRST  = 2;

    typedef struct packed {
        logic [7:0]        fcr;
        logic [BYTE_W-1:0] hold;
        logic              dr;
        logic              oe;
        logic              bi;
        logic              tpend;
    } rxb_state_t;

    // serial bits in one frame: start + data + optional parity + stop
    function automatic int frame_bits(input logic [3:0] fmt);
        int n;
        n = 1 + 5 + int'(fmt[1:0]);
        if (fmt[3]) n = n + 1;
        n = n + (fmt[2] ? 2 : 1);
        return n;
    endfunction

    function automatic int trig_bytes(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 din,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fptr_t;

    fptr_t p_d, p_q;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        p_d = p_q;
        if (clr) begin
            p_d = '0;
        end else begin
            if (push) p_d.wp = (p_q.wp == LAST) ? '0 : p_q.wp + 1'b1;
            if (pop)  p_d.rp = (p_q.rp == LAST) ? '0 : p_q.rp + 1'b1;
            case ({push, pop})
                2'b10:   p_d.cnt = p_q.cnt + 1'b1;
                2'b01:   p_d.cnt = p_q.cnt - 1'b1;
                default: p_d.cnt = p_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem[p_q.wp] <= din;
    end

    assign head  = mem[p_q.rp];
    assign count = p_q.cnt;

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |-> (p_q.cnt < CW'(DEPTH)) || pop);

    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clr) |-> (p_q.cnt != '0));

    a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr) |=> (p_q.cnt == $past(p_q.cnt) + 1'b1));

endmodule

// File: rtl/rxb_char_timer.sv
module rxb_char_timer
    import uart_rxb_pkg::*;
#(
    parameter int TOUT_CHARS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       halt,
    input  logic       tick,
    input  logic [3:0] fmt,
    output logic       expire
);
    localparam int MAX_TICKS = 12 * TOUT_CHARS;
    localparam int TW        = $clog2(MAX_TICKS + 1);

    typedef struct packed {
        logic          armed;
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t          t_d, t_q;
    logic [TW-1:0] limit;
    logic          reach;

    assign limit  = TW'(frame_bits(fmt) * TOUT_CHARS);
    assign reach  = (t_q.cnt + 1'b1) >= limit;
    assign expire = t_q.armed && tick && reach;

    always_comb begin
        t_d = t_q;
        if (restart) begin
            t_d.armed = 1'b1;
            t_d.cnt   = '0;
        end else if (halt) begin
            t_d = '0;
        end else if (t_q.armed && tick) begin
            if (reach) t_d = '0;
            else       t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // R10: the count advances only on tick pulses
    a_r10_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.armed && !tick && !restart && !halt) |=> $stable(t_q.cnt));

    a_r10_disarm_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !restart) |=> !t_q.armed);

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int TOUT_CHARS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rx_valid,
    input  logic [7:0]                  rx_data,
    input  logic                        rx_break,
    input  logic                        rd_req,
    input  logic                        stat_rd,
    input  logic                        fcr_wr,
    input  logic [7:0]                  fcr_wdata,
    input  logic [3:0]                  lcr_fmt,
    input  logic                        baud_tick,
    output logic [7:0]                  rd_data,
    output logic                        data_ready,
    output logic                        overrun,
    output logic                        break_seen,
    output logic                        timeout_pend,
    output logic [$clog2(DEPTH+1)-1:0]  fifo_count,
    output logic                        trig_hit,
    output logic [7:0]                  fcr_state
);
    localparam int            CW     = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    rxb_state_t          st_d, st_q;
    logic                q_clr, q_push, q_pop;
    logic [BYTE_W-1:0]   q_din, q_head;
    logic [CW-1:0]       q_cnt, cnt_after;
    logic                tmr_restart, tmr_halt, tmr_expire;
    logic [7:0]          wr_v;
    logic                rx_any, flush, fifo_mode;

    rxb_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (q_clr),
        .push  (q_push),
        .pop   (q_pop),
        .din   (q_din),
        .head  (q_head),
        .count (q_cnt)
    );

    rxb_char_timer #(.TOUT_CHARS(TOUT_CHARS)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .halt    (tmr_halt),
        .tick    (baud_tick),
        .fmt     (lcr_fmt),
        .expire  (tmr_expire)
    );

    assign rx_any    = rx_valid || rx_break;
    assign fifo_mode = st_q.fcr[FCR_EN];
    assign q_din     = rx_break ? '0 : rx_data;

    always_comb begin
        st_d        = st_q;
        q_clr       = 1'b0;
        q_push      = 1'b0;
        q_pop       = 1'b0;
        tmr_restart = 1'b0;
        tmr_halt    = 1'b0;
        flush       = 1'b0;
        wr_v        = fcr_wdata;
        cnt_after   = q_cnt;

        if (stat_rd) begin
            st_d.oe = 1'b0;
            st_d.bi = 1'b0;
        end

        if (fcr_wr) begin
            // a mode change forces both queue resets
            if (fcr_wdata[FCR_EN] != st_q.fcr[FCR_EN]) begin
                wr_v[FCR_RXRST] = 1'b1;
                wr_v[FCR_TXRST] = 1'b1;
            end
            flush    = wr_v[FCR_RXRST];
            st_d.fcr = wr_v & FCR_KEEP;
        end

        if (flush) begin
            // receive reset wins over any byte or read in this cycle
            q_clr      = 1'b1;
            tmr_halt   = 1'b1;
            st_d.dr    = 1'b0;
            st_d.bi    = 1'b0;
            st_d.tpend = 1'b0;
        end else if (fifo_mode) begin
            if (rd_req) begin
                st_d.tpend = 1'b0;
                if (q_cnt != '0) begin
                    q_pop = 1'b1;
                    if (q_cnt > CW'(1)) tmr_restart = 1'b1;
                end
            end
            if (rx_any) begin
                tmr_restart = 1'b1;
                if (q_cnt < FULL_C || q_pop) q_push = 1'b1;
                else                         st_d.oe = 1'b1;
                if (rx_break) st_d.bi = 1'b1;
            end
            case ({q_push, q_pop})
                2'b10:   cnt_after = q_cnt + 1'b1;
                2'b01:   cnt_after = q_cnt - 1'b1;
                default: cnt_after = q_cnt;
            endcase
            st_d.dr = (cnt_after != '0);
            if (cnt_after == '0) st_d.bi = 1'b0;
            if (tmr_expire && !tmr_restart && !rd_req && q_cnt != '0)
                st_d.tpend = 1'b1;
        end else begin
            if (rd_req) begin
                st_d.dr = 1'b0;
                st_d.bi = 1'b0;
            end
            if (rx_any) begin
                if (st_q.dr && !rd_req) st_d.oe = 1'b1;
                st_d.hold = q_din;
                st_d.dr   = 1'b1;
                if (rx_break) st_d.bi = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (fifo_mode) begin
            rd_data  = (q_cnt == '0) ? '0 : q_head;
            trig_hit = q_cnt >= CW'(trig_bytes(st_q.fcr[7:6]));
        end else begin
            rd_data  = st_q.hold;
            trig_hit = st_q.dr;
        end
    end

    assign data_ready   = st_q.dr;
    assign overrun      = st_q.oe;
    assign break_seen   = st_q.bi;
    assign timeout_pend = st_q.tpend;
    assign fifo_count   = q_cnt;
    assign fcr_state    = st_q.fcr;

    a_r4_ready_tracks_fill: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_mode |-> (st_q.dr == (q_cnt != '0)));

    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.oe && !stat_rd) |=> st_q.oe);

    a_r11_pend_from_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.tpend) |-> $past(tmr_expire));

    a_r2_single_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && st_q.dr && rx_valid && !rd_req && !fcr_wr) |=> st_q.oe);

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_wr && fcr_wdata[FCR_RXRST]) |=> (q_cnt == '0) && !st_q.dr && !st_q.tpend);

endmodule

// File: tb/test_uart_rx_buffer.sv
module test_uart_rx_buffer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0, rx_break = 1'b0, rd_req = 1'b0, stat_rd = 1'b0;
    logic       fcr_wr = 1'b0, baud_tick = 1'b0;
    logic [7:0] rx_data = '0, fcr_wdata = '0;
    logic [3:0] lcr_fmt = 4'b0011;
    logic [7:0] rd_data, fcr_state;
    logic       data_ready, overrun, break_seen, timeout_pend, trig_hit;
    logic [4:0] fifo_count;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    uart_rx_buffer i_uart_rx_buffer (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_break(rx_break), .rd_req(rd_req), .stat_rd(stat_rd),
        .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata), .lcr_fmt(lcr_fmt),
        .baud_tick(baud_tick), .rd_data(rd_data), .data_ready(data_ready),
        .overrun(overrun), .break_seen(break_seen), .timeout_pend(timeout_pend),
        .fifo_count(fifo_count), .trig_hit(trig_hit), .fcr_state(fcr_state)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic rx_byte(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic rx_brk();
        @(negedge clk); rx_break = 1'b1;
        @(negedge clk); rx_break = 1'b0;
    endtask

    task automatic wr_fcr(input logic [7:0] v);
        @(negedge clk); fcr_wr = 1'b1; fcr_wdata = v;
        @(negedge clk); fcr_wr = 1'b0;
    endtask

    task automatic read_exp(input string req, input int exp);
        @(negedge clk); rd_req = 1'b1;
        #1 chk(req, "rd_data", int'(rd_data), exp);
        @(negedge clk); rd_req = 1'b0;
    endtask

    task automatic read_status();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); baud_tick = 1'b1;
            @(negedge clk); baud_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk("R1", "fcr_state", int'(fcr_state), 0);
        chk("R1", "fifo_count", int'(fifo_count), 0);
        chk("R1", "flags", int'({data_ready, overrun, break_seen, timeout_pend}), 0);
    endtask

    task automatic t_single();
        rx_byte(8'h11);
        chk("R2", "dr after first", int'(data_ready), 1);
        chk("R2", "no overrun", int'(overrun), 0);
        chk("R2", "trig follows dr", int'(trig_hit), 1);
        rx_byte(8'h22);
        chk("R2", "overrun on second", int'(overrun), 1);
        read_exp("R2", 8'h22);
        chk("R2", "dr cleared by read", int'(data_ready), 0);
        read_status();
        chk("R6", "overrun cleared", int'(overrun), 0);
        rx_brk();
        chk("R5", "break byte single", int'(rd_data), 0);
        chk("R5", "break+dr single", int'({break_seen, data_ready}), 3);
        read_exp("R5", 0);
        chk("R2", "read clears break", int'({break_seen, data_ready}), 0);
    endtask

    task automatic t_mask();
        wr_fcr(8'hFF);
        chk("R7", "masked value", int'(fcr_state), 8'hC9);
        wr_fcr(8'h00);
        chk("R7", "back to zero", int'(fcr_state), 0);
    endtask

    task automatic t_fill();
        wr_fcr(8'h01);
        chk("R7", "enable kept", int'(fcr_state), 1);
        for (int i = 0; i < 16; i++) rx_byte(8'h30 + 8'(i));
        chk("R3", "full count", int'(fifo_count), 16);
        chk("R3", "no overrun yet", int'(overrun), 0);
        rx_byte(8'hEE);
        chk("R3", "overrun on full", int'(overrun), 1);
        chk("R3", "count stays full", int'(fifo_count), 16);
        for (int i = 0; i < 16; i++) read_exp("R3", 8'h30 + i);
        chk("R4", "empty clears dr", int'(data_ready), 0);
        read_exp("R4", 0);
        chk("R6", "overrun held", int'(overrun), 1);
        read_status();
        chk("R6", "overrun cleared", int'(overrun), 0);
    endtask

    task automatic t_break();
        rx_byte(8'h5A);
        rx_brk();
        chk("R5", "break count", int'(fifo_count), 2);
        chk("R5", "break+dr", int'({break_seen, data_ready}), 3);
        read_exp("R5", 8'h5A);
        chk("R4", "break held while data", int'(break_seen), 1);
        read_exp("R5", 0);
        chk("R4", "empty clears break", int'({break_seen, data_ready}), 0);
        rx_brk();
        read_status();
        chk("R6", "status clears break only", int'({break_seen, data_ready}), 1);
        read_exp("R5", 0);
    endtask

    task automatic t_trigger();
        for (int s = 0; s < 4; s++) begin
            int lvl;
            lvl = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
            wr_fcr({2'(s), 6'b000011});
            for (int i = 0; i < lvl - 1; i++) rx_byte(8'(i));
            chk("R9", "below level", int'(trig_hit), 0);
            rx_byte(8'hA5);
            chk("R9", "at level", int'(trig_hit), 1);
        end
    endtask

    task automatic t_flush();
        wr_fcr(8'h03);
        rx_byte(8'h01); rx_byte(8'h02);
        wr_fcr(8'h81);
        chk("R8", "no flush without reset bit", int'(fifo_count), 2);
        wr_fcr(8'hC3);
        chk("R8", "reset bit flushes", int'({fifo_count, data_ready}), 0);
        chk("R7", "reset bit not kept", int'(fcr_state), 8'hC1);
        rx_byte(8'h07);
        wr_fcr(8'h00);
        chk("R8", "mode change flushes", int'({fifo_count, data_ready}), 0);
        rx_byte(8'h09);
        wr_fcr(8'h01);
        chk("R8", "mode change clears dr", int'(data_ready), 0);
    endtask

    task automatic t_timeout();
        lcr_fmt = 4'b0011;
        wr_fcr(8'h03);
        rx_byte(8'h41);
        ticks(39);
        chk("R10", "not yet at 39", int'(timeout_pend), 0);
        ticks(1);
        chk("R10", "pending at 40", int'(timeout_pend), 1);
        read_exp("R11", 8'h41);
        chk("R11", "read clears pending", int'(timeout_pend), 0);
        lcr_fmt = 4'b1100;
        rx_byte(8'h42);
        ticks(35);
        chk("R10", "not yet at 35", int'(timeout_pend), 0);
        ticks(1);
        chk("R10", "pending at 36", int'(timeout_pend), 1);
        wr_fcr(8'h03);
        chk("R8", "flush clears pending", int'(timeout_pend), 0);
        lcr_fmt = 4'b0011;
        rx_byte(8'h51); rx_byte(8'h52);
        ticks(30);
        read_exp("R11", 8'h51);
        ticks(39);
        chk("R11", "restart by partial read", int'(timeout_pend), 0);
        ticks(1);
        chk("R11", "pending after restart", int'(timeout_pend), 1);
        read_exp("R11", 8'h52);
        rx_byte(8'h61);
        read_exp("R11", 8'h61);
        ticks(40);
        chk("R11", "expiry on empty ignored", int'(timeout_pend), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_mask();
        t_fill();
        t_break();
        t_trigger();
        t_flush();
        t_timeout();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule